// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the bus-facing side of a byte-wide serial memory with 131,072 locations. It oversamples the serial clock and data lines on a fast system clock, finds start and stop conditions, and shifts address and data bytes in and out. Acknowledge and read-data bits go onto the line through an open-drain enable: when `sdaDriveLow` is high the pad pulls SDA to 0, and otherwise the line is left to its pull-up.

A transaction opens with a device byte that names the target and the direction and carries the top bit of a 17-bit word address. A write continues with two more address bytes and any number of data bytes. Each data byte goes to a separate storage engine as an address/data strobe, and that engine is told to commit when the stop arrives. While the engine reports busy, the target does not acknowledge its device byte, so a master can poll until the store is complete. Reads come from a synchronous RAM port with one cycle of latency. A word-address counter is kept between transactions, which supports current-address, random and sequential reads.

Top module: `twoWireMemTarget`

## Requirements
- R1: A stop (SDA rising while SCL is high) returns the target to idle at any point. A start (SDA falling while SCL is high) at any point, including part-way through a byte, restarts device-byte reception. A transaction cut short in this way leaves the word-address counter unchanged.
- R2: The device byte is received MSB first as 1,0,1,0,0, then a bit that must equal `a1Pin`, then page bit P0, then the direction bit (1 = read, 0 = write). On a match the target acknowledges on the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R3: In a write, P0 from the device byte, the first address byte and the second address byte form the 17-bit word address, most significant first. The first data byte is presented on `wrAddr`/`wrData` with a one-cycle `wrReq`. A stop after at least one data byte gives a one-cycle `wrCommit`.
- R4: Each address byte and data byte of a write is acknowledged with SDA low on the ninth clock.
- R5: Each further data byte in a write goes to the next address. Only the low 8 bits count up, so a write that passes the end of a 256-byte page wraps to the start of the same page.
- R6: A read with no address phase (current-address read) starts at the address that follows the last byte written or read. This counter persists across transactions.
- R7: In a sequential read, each acknowledge from the master advances the address by one over the full 17 bits, so 0x1FFFF is followed by 0x00000.
- R8: A random read is an address phase in the write direction with no data, then a repeated start and a device byte in the read direction. It returns the byte at the loaded address.
- R9: When the master does not acknowledge a read byte, the target releases SDA and stays released through the following stop.
- R10: While `wrBusy` is high, the device byte is not acknowledged in either direction. Once `wrBusy` is low, it is acknowledged again.
- R11: Read bytes are sent MSB first. The target only starts pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad (wired value) |
| a1Pin | input | 1 | Strap value that device-byte bit 2 must match; tie to 0 when unused |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| wrBusy | input | 1 | Storage engine is running an internal write cycle |
| wrReq | output | 1 | One-cycle strobe: store `wrData` at `wrAddr` |
| wrAddr | output | 17 | Word address of the byte to store |
| wrData | output | 8 | Byte to store |
| wrCommit | output | 1 | One-cycle strobe at the stop that ends a write with data |
| memRdEn | output | 1 | Read enable to the synchronous RAM |
| memRdAddr | output | 17 | Read address to the RAM |
| memRdData | input | 8 | RAM read data, valid the cycle after `memRdEn` |

## Verification
The hardest situations to reach are the ones that depend on history: the device-byte refusal while the storage engine is still busy, and the word-address counter surviving page wraps, aborted transactions and full-memory rollover. The bench reaches the busy window by polling at once after a write's stop, using a storage-engine model that holds `wrBusy` for far longer than one byte takes. A bit-level master then aborts a device byte part-way with a repeated start, stops after only the high address byte, and writes across the last byte of a page. Each of these is followed by a current-address read, so the counter is exposed at the ports.

// File: rtl/twmt_pkg.sv
package twmt_pkg;
  localparam int ADDR_W = 17;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK
  } busState_e;

  typedef enum logic [1:0] {
    K_DEV, K_HI, K_LO, K_DATA
  } byteKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic countBit;
    logic clrBits;
    logic latchDev;
    logic loadHi;
    logic loadAddr;
    logic storeByte;
    logic fetchRd;
    logic incRd;
    logic driveAck;
    logic driveTx;
    logic releaseSda;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/twmt_sync.sv
module twmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int DEPTH = (STAGES < 2) ? 3 : STAGES + 1;

  logic [DEPTH-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[DEPTH-2:0], sclIn};
      sdaPipe <= {sdaPipe[DEPTH-2:0], sdaIn};
    end
  end

  assign sclS = sclPipe[DEPTH-2];
  assign sdaS = sdaPipe[DEPTH-2];
  assign sclD = sclPipe[DEPTH-1];
  assign sdaD = sdaPipe[DEPTH-1];

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/twmt_ctrl.sv
module twmt_ctrl
  import twmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaS,
  input  logic [3:0] bitCnt,
  input  logic       devAck,
  input  logic       devRead,
  output dpStrobe_t  st
);
  busState_e state, stateN;
  byteKind_e kind, kindN;
  logic readMode, readModeN;
  logic masterAck, masterAckN;
  logic dataSeen, dataSeenN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_DEV;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      dataSeen  <= 1'b0;
    end else begin
      state     <= stateN;
      kind      <= kindN;
      readMode  <= readModeN;
      masterAck <= masterAckN;
      dataSeen  <= dataSeenN;
    end
  end

  always_comb begin
    st         = '0;
    stateN     = state;
    kindN      = kind;
    readModeN  = readMode;
    masterAckN = masterAck;
    dataSeenN  = dataSeen;
    if (stopEv) begin
      stateN        = ST_IDLE;
      st.releaseSda = 1'b1;
      st.commit     = dataSeen;
      dataSeenN     = 1'b0;
    end else if (startEv) begin
      stateN        = ST_RX;
      kindN         = K_DEV;
      st.clrBits    = 1'b1;
      st.releaseSda = 1'b1;
      dataSeenN     = 1'b0;
      masterAckN    = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && !bitCnt[3]) begin
            st.shiftIn  = 1'b1;
            st.countBit = 1'b1;
          end else if (sclFall && bitCnt[3]) begin
            st.clrBits = 1'b1;
            unique case (kind)
              K_DEV: begin
                if (devAck) begin
                  stateN      = ST_ACK;
                  st.driveAck = 1'b1;
                  st.latchDev = 1'b1;
                  readModeN   = devRead;
                  st.fetchRd  = devRead;
                end else begin
                  stateN = ST_IDLE;
                end
              end
              K_HI: begin
                stateN      = ST_ACK;
                st.driveAck = 1'b1;
                st.loadHi   = 1'b1;
              end
              K_LO: begin
                stateN      = ST_ACK;
                st.driveAck = 1'b1;
                st.loadAddr = 1'b1;
              end
              default: begin
                stateN       = ST_ACK;
                st.driveAck  = 1'b1;
                st.storeByte = 1'b1;
                dataSeenN    = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (readMode) begin
              stateN     = ST_TX;
              st.driveTx = 1'b1;
            end else begin
              stateN        = ST_RX;
              st.releaseSda = 1'b1;
              unique case (kind)
                K_DEV:   kindN = K_HI;
                K_HI:    kindN = K_LO;
                default: kindN = K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            st.countBit = 1'b1;
          end else if (sclFall) begin
            if (bitCnt[3]) begin
              stateN        = ST_RACK;
              st.releaseSda = 1'b1;
              st.clrBits    = 1'b1;
              st.incRd      = 1'b1;
            end else begin
              st.driveTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            if (!sdaS) begin
              masterAckN = 1'b1;
              st.fetchRd = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end else if (sclFall && masterAck) begin
            stateN     = ST_TX;
            st.driveTx = 1'b1;
            masterAckN = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twmt_dp.sv
module twmt_dp
  import twmt_pkg::*;
#(
  parameter int          PAGE_W   = 8,
  parameter logic [4:0]  DEV_CODE = 5'b10100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              sdaS,
  input  logic              a1Pin,
  input  logic              wrBusy,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [3:0]        bitCnt,
  output logic              devAck,
  output logic              devRead,
  output logic              sdaDriveLow,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrCommit,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr
);
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [BYTE_W-1:0] rxShift, hiHold, txByte;
  logic              p0Hold, rdValid;
  logic [ADDR_W-1:0] addrCnt;

  assign devAck  = (rxShift[7:3] == DEV_CODE) && (rxShift[2] == a1Pin) && !wrBusy;
  assign devRead = rxShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift     <= '0;
      hiHold      <= '0;
      txByte      <= '0;
      p0Hold      <= 1'b0;
      rdValid     <= 1'b0;
      addrCnt     <= '0;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
      wrReq       <= 1'b0;
      wrAddr      <= '0;
      wrData      <= '0;
      wrCommit    <= 1'b0;
      memRdEn     <= 1'b0;
      memRdAddr   <= '0;
    end else begin
      if (st.clrBits)       bitCnt <= '0;
      else if (st.countBit) bitCnt <= bitCnt + 4'd1;

      if (st.shiftIn)  rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (st.latchDev) p0Hold  <= rxShift[1];
      if (st.loadHi)   hiHold  <= rxShift;

      wrReq <= st.storeByte;
      if (st.storeByte) begin
        wrAddr <= addrCnt;
        wrData <= rxShift;
      end

      if (st.loadAddr)
        addrCnt <= {p0Hold, hiHold, rxShift};
      else if (st.storeByte)
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + PAGE_ONE};
      else if (st.incRd)
        addrCnt <= addrCnt + ADDR_ONE;

      memRdEn <= st.fetchRd;
      if (st.fetchRd) memRdAddr <= addrCnt;
      rdValid <= memRdEn;
      if (rdValid) txByte <= memRdData;

      if (st.releaseSda)    sdaDriveLow <= 1'b0;
      else if (st.driveAck) sdaDriveLow <= 1'b1;
      else if (st.driveTx)  sdaDriveLow <= ~txByte[~bitCnt[2:0]];

      wrCommit <= st.commit;
    end
  end
endmodule

// File: rtl/twoWireMemTarget.sv
module twoWireMemTarget
  import twmt_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              a1Pin,
  output logic              sdaDriveLow,
  input  logic              wrBusy,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrCommit,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [BYTE_W-1:0] memRdData
);
  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  logic [3:0] bitCnt;
  logic devAck, devRead;
  dpStrobe_t st;

  twmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  twmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaS(sdaS), .bitCnt(bitCnt),
    .devAck(devAck), .devRead(devRead), .st(st)
  );

  twmt_dp #(.PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .sdaS(sdaS), .a1Pin(a1Pin),
    .wrBusy(wrBusy), .memRdData(memRdData), .bitCnt(bitCnt),
    .devAck(devAck), .devRead(devRead), .sdaDriveLow(sdaDriveLow),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr)
  );
endmodule

// File: rtl/twmtChecker.sv
module twmtChecker (
  input logic clk,
  input logic rstN,
  input logic sclS,
  input logic sdaDriveLow,
  input logic wrReq,
  input logic wrCommit,
  input logic wrBusy,
  input logic memRdEn
);
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclS);

  assert_no_store_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrBusy |-> !wrReq);

  assert_store_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);

  assert_commit_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  assert_read_write_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && wrReq));
endmodule

bind twoWireMemTarget twmtChecker chk_i (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaDriveLow(sdaDriveLow),
  .wrReq(wrReq), .wrCommit(wrCommit), .wrBusy(wrBusy), .memRdEn(memRdEn)
);

// File: tb/twoWireMemTarget_tb_top.sv
module twoWireMemTarget_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int BUSY_LEN   = 1500;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, a1Pin = 1'b0;
  logic sdaDriveLow, wrReq, wrCommit, memRdEn;
  logic [16:0] wrAddr, memRdAddr;
  logic [7:0] wrData, memRdData;
  logic wrBusy;
  logic sdaBus;
  int busyCnt = 0;
  int nChecks = 0, nFails = 0;
  int curAddr = 0;
  logic [7:0] mem [int];
  int rdExpQ[$], rdGotQ[$], wrExpAQ[$], wrExpDQ[$];
  string rdTagQ[$], wrTagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaBus = sdaM & ~sdaDriveLow;
  assign wrBusy = (busyCnt != 0);

  twoWireMemTarget dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .a1Pin(a1Pin),
    .sdaDriveLow(sdaDriveLow), .wrBusy(wrBusy), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .wrCommit(wrCommit), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData)
  );

  function automatic logic [7:0] patt(int a);
    return 8'((a * 37) ^ (a >> 9));
  endfunction

  function automatic logic [7:0] rdFn(int a);
    int k = a & 32'h1FFFF;
    return mem.exists(k) ? mem[k] : patt(k);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // RAM model, one-cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= rdFn(int'(memRdAddr));

  // storage-engine model and write scoreboard
  always @(negedge clk) begin
    if (busyCnt != 0) busyCnt <= busyCnt - 1;
    if (wrCommit) busyCnt <= BUSY_LEN;
    if (wrReq) begin
      mem[int'(wrAddr)] = wrData;
      if (wrExpAQ.size() == 0) check(1'b0, "R3 unexpected store", int'(wrAddr), -1);
      else begin
        automatic int ea = wrExpAQ.pop_front();
        automatic int ed = wrExpDQ.pop_front();
        automatic string t = wrTagQ.pop_front();
        check(int'(wrAddr) == ea, {t, " store address"}, int'(wrAddr), ea);
        check(int'(wrData) == ed, {t, " store data"}, int'(wrData), ed);
      end
    end
  end

  // read scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (rdGotQ.size() != 0) begin
      automatic int g = rdGotQ.pop_front();
      automatic int e = rdExpQ.pop_front();
      automatic string t = rdTagQ.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC;
    sdaM = 1; tick(HALF); sclM = 1; tick(HALF); sdaM = 0; tick(HALF); sclM = 0; tick(HALF);
  endtask

  task automatic stopC;
    sdaM = 0; tick(HALF); sclM = 1; tick(HALF); sdaM = 1; tick(HALF);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(HALF); sclM = 1; tick(HALF); sclM = 0; tick(HALF);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaM = 1; tick(HALF); sclM = 1; tick(HALF);
    ack = ~sdaBus;
    sclM = 0; tick(HALF);
  endtask

  task automatic recvByte(bit mAck, output logic [7:0] b);
    sdaM = 1;
    for (int i = 0; i < 8; i++) begin
      tick(HALF); sclM = 1; tick(HALF); b = {b[6:0], sdaBus}; sclM = 0;
    end
    tick(HALF); sdaM = mAck ? 1'b0 : 1'b1; tick(HALF); sclM = 1; tick(HALF);
    if (!mAck) check(sdaDriveLow == 1'b0, "R9 released after master nack", int'(sdaDriveLow), 0);
    sclM = 0; tick(HALF); sdaM = 1;
  endtask

  function automatic logic [7:0] devByte(bit p0, bit rd);
    return {5'b10100, a1Pin, p0, rd};
  endfunction

  task automatic addrPhase(int a, string tag);
    bit ack;
    startC;
    sendByte(devByte(a[16], 1'b0), ack); check(ack, {tag, " device ack"}, ack, 1);
    sendByte(a[15:8], ack); check(ack, "R4 high address ack", ack, 1);
    sendByte(a[7:0], ack);  check(ack, "R4 low address ack", ack, 1);
    curAddr = a & 32'h1FFFF;
  endtask

  task automatic readSeq(int n, string tag);
    bit ack;
    logic [7:0] b;
    startC;
    sendByte(devByte(1'b0, 1'b1), ack); check(ack, {tag, " read device ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      rdExpQ.push_back(int'(rdFn(curAddr)));
      rdGotQ.push_back(int'(b));
      rdTagQ.push_back({tag, " R11 read byte"});
      curAddr = (curAddr + 1) & 32'h1FFFF;
    end
    stopC;
    check(sdaDriveLow == 1'b0, "R9 released after stop", int'(sdaDriveLow), 0);
  endtask

  task automatic writeData(int a, int n, logic [7:0] d0, logic [7:0] d1, logic [7:0] d2, string tag);
    bit ack;
    logic [7:0] d;
    addrPhase(a, tag);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      wrExpAQ.push_back((a & 32'h1FF00) | ((a + i) & 32'hFF));
      wrExpDQ.push_back(int'(d));
      wrTagQ.push_back(tag);
      sendByte(d, ack); check(ack, "R4 data ack", ack, 1);
    end
    curAddr = (a & 32'h1FF00) | ((a + n) & 32'hFF);
    stopC;
  endtask

  task automatic waitIdle;
    while (wrBusy) tick(1);
  endtask

  initial begin
    bit ack;
    tick(5);
    check(sdaDriveLow == 1'b0 && wrReq == 1'b0 && memRdEn == 1'b0,
          "R9 reset leaves bus released", int'({sdaDriveLow, wrReq, memRdEn}), 0);
    rstN = 1; tick(5);

    // byte write, then poll while busy
    writeData(32'h12345, 1, 8'hA5, 8'h00, 8'h00, "R3");
    tick(20);
    check(wrBusy == 1'b1, "R3 commit started engine", int'(wrBusy), 1);
    startC;
    sendByte(devByte(1'b0, 1'b0), ack); check(!ack, "R10 no ack while busy (write)", ack, 0);
    stopC;
    startC;
    sendByte(devByte(1'b0, 1'b1), ack); check(!ack, "R10 no ack while busy (read)", ack, 0);
    stopC;
    waitIdle;
    readSeq(1, "R10 R6");

    // random read and current read
    addrPhase(32'h12345, "R8");
    readSeq(1, "R8");
    readSeq(1, "R6");

    // page write crossing the page end
    waitIdle;
    writeData(32'h001FE, 3, 8'h11, 8'h22, 8'h33, "R5");
    waitIdle;
    readSeq(1, "R5 R6");
    addrPhase(32'h001FE, "R7");
    readSeq(3, "R7");
    addrPhase(32'h00100, "R5");
    readSeq(1, "R5");

    // rollover of the whole memory
    addrPhase(32'h1FFFE, "R7");
    readSeq(3, "R7 wrap");
    check(curAddr == 1, "R7 model wrapped", curAddr, 1);

    // device byte mismatch
    startC;
    sendByte(8'hB1, ack); check(!ack, "R2 wrong code not acked", ack, 0);
    sendByte(8'hA0, ack); check(!ack, "R2 ignored after mismatch", ack, 0);
    stopC;
    startC;
    sendByte({5'b10100, 1'b1, 2'b01}, ack); check(!ack, "R2 a1 mismatch not acked", ack, 0);
    stopC;
    a1Pin = 1; tick(4);
    readSeq(1, "R2 a1 strapped high");
    a1Pin = 0; tick(4);

    // start inside a byte aborts it
    startC;
    sendBits(devByte(1'b0, 1'b0), 4);
    readSeq(1, "R1 restart");

    // stop after the high address byte leaves the counter alone
    startC;
    sendByte(devByte(1'b1, 1'b0), ack); check(ack, "R1 device ack", ack, 1);
    sendByte(8'h77, ack); check(ack, "R4 high address ack", ack, 1);
    stopC;
    readSeq(2, "R1 counter kept");

    tick(50);
    check(wrExpAQ.size() == 0, "R3 all stores seen", wrExpAQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule